// File: doc/BRIEF.md
# Line Fragment Splitter

This block accepts one memory access at a time: a base address, a byte count, a per-byte enable mask, a direction, an atomic flag and write data. It cuts the access into pieces so that no piece crosses an aligned line boundary. The line width is a power-of-two parameter. The first piece runs from the base address to the end of its line. Whole lines follow. A final partial piece covers whatever remains.

Pieces whose slice of the enable mask is empty are never emitted. The remaining pieces leave in ascending address order on a valid/ready request channel. Responses return in issue order on a second valid/ready channel. Read bytes from each response are placed into a full-width result at the piece's offset from the base address. When every emitted piece has been answered, a completion beat carries the result, an error flag, an illegal flag and the number of pieces emitted.

An atomic access that would need more than one piece is refused. It completes at once with the illegal flag set, and no piece is emitted.

Back-pressure rules:
- A new access is taken only while `cmd_ready` is high, which is only when the block is idle.
- A request beat stays stable while `frg_valid` is high and `frg_ready` is low.
- `rsp_ready` is high only while at least one issued piece is still unanswered.
- The completion beat holds until `done_ready` is high.

Top module: `line_frag_splitter`

## Requirements
- R1: The first piece starts at the base address. Its length is the line width minus the base address's offset within its line, or the whole access size if that is smaller. Each further piece starts where the previous one ended. Each further piece is a full line, except the last, which holds the remainder.
- R2: An access that fits inside one aligned line produces exactly one piece, with the base address and the full size.
- R3: A piece whose slice of `cmd_be` is all zero is not emitted. It is not counted in `done_nfrag`. Every emitted piece has at least one enable bit set.
- R4: Pieces are emitted one beat at a time, in strictly ascending address order. A beat is held stable until it is accepted.
- R5: No emitted piece crosses a line boundary: the address offset within the line plus the piece length is at most the line width.
- R6: For each answered piece without error, response byte k (k less than the piece length) appears in `done_rdata` at byte (piece address − base address + k). All other result bytes read zero.
- R7: A response with `rsp_err` high contributes no data, and it sets `done_err` for the access.
- R8: The completion beat appears only after the number of responses equals the number of emitted pieces. `done_nfrag` reports that number.
- R9: If `cmd_atomic` is set and the access would need more than one piece, no piece is emitted. The access then completes with `done_illegal` = 1 and `done_nfrag` = 0.
- R10: An access whose pieces are all disabled completes with `done_nfrag` = 0, a zero result and no error, without emitting any request.
- R11: After reset, and between accesses, `cmd_ready` is 1 and `frg_valid`, `rsp_ready` and `done_valid` are 0. A completion beat holds its values until `done_ready` is sampled high.
- R12: `frg_be` and `frg_wdata` are the slices of the access mask and write data that start at the piece's byte offset. They are low-justified, and bytes at or above the piece length are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Access offered |
| cmd_ready | output | 1 | Block idle, access taken this cycle if offered |
| cmd_addr | input | ADDR_W | Base byte address |
| cmd_size | input | $clog2(MAX_BYTES+1) | Access length in bytes, 1..MAX_BYTES |
| cmd_be | input | MAX_BYTES | Per-byte enable, bit i for base+i |
| cmd_write | input | 1 | 1 for write, 0 for read |
| cmd_atomic | input | 1 | Access is atomic |
| cmd_wdata | input | 8*MAX_BYTES | Write data, byte i for base+i |
| frg_valid | output | 1 | Piece request valid |
| frg_ready | input | 1 | Piece request accepted |
| frg_addr | output | ADDR_W | Piece start address |
| frg_size | output | $clog2(LINE_BYTES+1) | Piece length in bytes |
| frg_be | output | LINE_BYTES | Piece enables, low-justified |
| frg_write | output | 1 | Direction of the access |
| frg_wdata | output | 8*LINE_BYTES | Piece write data, low-justified |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Response accepted |
| rsp_err | input | 1 | Response reports failure |
| rsp_rdata | input | 8*LINE_BYTES | Response read data, low-justified |
| done_valid | output | 1 | Completion beat valid |
| done_ready | input | 1 | Completion beat taken |
| done_rdata | output | 8*MAX_BYTES | Reassembled result |
| done_err | output | 1 | Some piece failed |
| done_illegal | output | 1 | Atomic access refused |
| done_nfrag | output | $clog2(MAXF+1) | Pieces emitted |

## Verification
The embedded properties assume three things about the inputs:
- `cmd_size` lies between 1 and MAX_BYTES.
- Responses come back in the order the pieces were accepted.
- Addresses do not wrap past the top of the address space within one access.

The stimulus meets these assumptions as follows. It draws sizes from that range and keeps base addresses well below the top. Its responder answers only pieces it has already seen accepted, strictly in order, so `rsp_valid` is never raised for an unissued piece. Request readiness, response validity and completion readiness are randomly stalled, so the holding rules are exercised while the inputs stay legal.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_RUN  = 2'd1,
    FS_DONE = 2'd2
  } fs_state_e;
endpackage

// File: rtl/fsp_plan.sv
// Computes, for every possible piece position, its offset from the base,
// its length, whether it exists and whether any of its bytes are enabled.
module fsp_plan #(
  parameter int LINE_BYTES = 8,
  parameter int MAX_BYTES  = 16,
  parameter int MAXF       = 3,
  parameter int SZ_W       = 5,
  parameter int OFF_W      = 4,
  parameter int LEN_W      = 4,
  parameter int LINE_LOG   = 3
) (
  input  logic [LINE_LOG-1:0]          line_off,
  input  logic [SZ_W-1:0]              size,
  input  logic [MAX_BYTES-1:0]         be,
  output logic [MAXF-1:0][OFF_W-1:0]   p_off,
  output logic [MAXF-1:0][LEN_W-1:0]   p_len,
  output logic [MAXF-1:0]              p_present,
  output logic [MAXF-1:0]              p_en
);
  localparam int W = $clog2(MAX_BYTES + LINE_BYTES + 1) + 1;

  logic [W-1:0] first_w;
  logic [W-1:0] size_w;

  assign first_w = W'(LINE_BYTES) - W'(line_off);
  assign size_w  = W'(size);

  for (genvar gi = 0; gi < MAXF; gi++) begin : g_piece
    logic [W-1:0]           start_w;
    logic [W-1:0]           cap_w;
    logic [W-1:0]           rem_w;
    logic [W-1:0]           len_w;
    logic [MAX_BYTES:0]     lmask;
    logic [MAX_BYTES-1:0]   be_sh;

    if (gi == 0) begin : g_head
      assign start_w = '0;
      assign cap_w   = first_w;
    end else begin : g_tail
      assign start_w = first_w + W'((gi - 1) * LINE_BYTES);
      assign cap_w   = W'(LINE_BYTES);
    end

    assign rem_w = size_w - start_w;
    assign len_w = (rem_w < cap_w) ? rem_w : cap_w;
    assign lmask = ({{MAX_BYTES{1'b0}}, 1'b1} << len_w) - {{MAX_BYTES{1'b0}}, 1'b1};
    assign be_sh = be >> start_w;

    assign p_present[gi] = (start_w < size_w);
    assign p_en[gi]      = p_present[gi] && (|(be_sh & lmask[MAX_BYTES-1:0]));
    assign p_off[gi]     = OFF_W'(start_w);
    assign p_len[gi]     = LEN_W'(len_w);
  end
endmodule

// File: rtl/fsp_slice.sv
// Extracts the low-justified enable and write-data slice of one piece.
module fsp_slice #(
  parameter int LINE_BYTES = 8,
  parameter int MAX_BYTES  = 16,
  parameter int OFF_W      = 4,
  parameter int LEN_W      = 4
) (
  input  logic [MAX_BYTES-1:0]     be_all,
  input  logic [MAX_BYTES*8-1:0]   wd_all,
  input  logic [OFF_W-1:0]         off,
  input  logic [LEN_W-1:0]         len,
  output logic [LINE_BYTES-1:0]    piece_be,
  output logic [LINE_BYTES*8-1:0]  piece_wd
);
  localparam int EXT = MAX_BYTES + LINE_BYTES;

  logic [EXT-1:0]        be_ext;
  logic [EXT*8-1:0]      wd_ext;
  logic [LINE_BYTES:0]   lmask;

  assign be_ext = {{LINE_BYTES{1'b0}}, be_all} >> off;
  assign wd_ext = {{(LINE_BYTES*8){1'b0}}, wd_all} >> {off, 3'b000};
  assign lmask  = ({{LINE_BYTES{1'b0}}, 1'b1} << len) - {{LINE_BYTES{1'b0}}, 1'b1};

  for (genvar gb = 0; gb < LINE_BYTES; gb++) begin : g_byte
    assign piece_be[gb]          = be_ext[gb] & lmask[gb];
    assign piece_wd[gb*8 +: 8]   = lmask[gb] ? wd_ext[gb*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/fsp_assemble.sv
// Result buffer: pastes answered piece data at its byte offset, tracks errors.
module fsp_assemble #(
  parameter int LINE_BYTES = 8,
  parameter int MAX_BYTES  = 16,
  parameter int OFF_W      = 4,
  parameter int LEN_W      = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr,
  input  logic [OFF_W-1:0]         off,
  input  logic [LEN_W-1:0]         len,
  input  logic                     err_in,
  input  logic [LINE_BYTES*8-1:0]  rdata,
  output logic [MAX_BYTES*8-1:0]   result,
  output logic                     err_out
);
  localparam int EXT = MAX_BYTES + LINE_BYTES;

  logic [LINE_BYTES:0]   lmask;
  logic [EXT-1:0]        bmask;
  logic [EXT*8-1:0]      dext;

  assign lmask = ({{LINE_BYTES{1'b0}}, 1'b1} << len) - {{LINE_BYTES{1'b0}}, 1'b1};
  assign bmask = {{MAX_BYTES{1'b0}}, lmask[LINE_BYTES-1:0]} << off;
  assign dext  = {{(MAX_BYTES*8){1'b0}}, rdata} << {off, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      err_out <= 1'b0;
    end else if (clr) begin
      result  <= '0;
      err_out <= 1'b0;
    end else if (wr) begin
      if (err_in) begin
        err_out <= 1'b1;
      end else begin
        for (int b = 0; b < MAX_BYTES; b++) begin
          if (bmask[b]) result[b*8 +: 8] <= dext[b*8 +: 8];
        end
      end
    end
  end

  AST_PASTE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> ((OFF_W+LEN_W+1)'(off) + (OFF_W+LEN_W+1)'(len)) <= (OFF_W+LEN_W+1)'(MAX_BYTES)); // R6
endmodule

// File: rtl/line_frag_splitter.sv
module line_frag_splitter
  import fsp_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 8,
  parameter int MAX_BYTES  = 16,
  localparam int LINE_LOG  = $clog2(LINE_BYTES),
  localparam int SZ_W      = $clog2(MAX_BYTES + 1),
  localparam int OFF_W     = $clog2(MAX_BYTES),
  localparam int LEN_W     = $clog2(LINE_BYTES + 1),
  localparam int MAXF      = (MAX_BYTES + LINE_BYTES - 2) / LINE_BYTES + 1,
  localparam int CNT_W     = $clog2(MAXF + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [SZ_W-1:0]          cmd_size,
  input  logic [MAX_BYTES-1:0]     cmd_be,
  input  logic                     cmd_write,
  input  logic                     cmd_atomic,
  input  logic [MAX_BYTES*8-1:0]   cmd_wdata,
  output logic                     frg_valid,
  input  logic                     frg_ready,
  output logic [ADDR_W-1:0]        frg_addr,
  output logic [LEN_W-1:0]         frg_size,
  output logic [LINE_BYTES-1:0]    frg_be,
  output logic                     frg_write,
  output logic [LINE_BYTES*8-1:0]  frg_wdata,
  input  logic                     rsp_valid,
  output logic                     rsp_ready,
  input  logic                     rsp_err,
  input  logic [LINE_BYTES*8-1:0]  rsp_rdata,
  output logic                     done_valid,
  input  logic                     done_ready,
  output logic [MAX_BYTES*8-1:0]   done_rdata,
  output logic                     done_err,
  output logic                     done_illegal,
  output logic [CNT_W-1:0]         done_nfrag
);
  fs_state_e                   st;
  logic [ADDR_W-1:0]           base_q;
  logic [MAX_BYTES-1:0]        be_q;
  logic [MAX_BYTES*8-1:0]      wd_q;
  logic                        wr_q;
  logic                        ill_q;
  logic [MAXF-1:0][OFF_W-1:0]  tbl_off_q, n_off;
  logic [MAXF-1:0][LEN_W-1:0]  tbl_len_q, n_len;
  logic [CNT_W-1:0]            gen_q, iss_q, ret_q, n_cnt;

  logic [MAXF-1:0][OFF_W-1:0]  p_off;
  logic [MAXF-1:0][LEN_W-1:0]  p_len;
  logic [MAXF-1:0]             p_present;
  logic [MAXF-1:0]             p_en;
  logic                        multi;

  logic                        cmd_fire, frg_fire, rsp_fire;
  logic [OFF_W-1:0]            iss_off, ret_off;
  logic [LEN_W-1:0]            ret_len;

  fsp_plan #(
    .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .MAXF(MAXF),
    .SZ_W(SZ_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .LINE_LOG(LINE_LOG)
  ) u_plan (
    .line_off  (cmd_addr[LINE_LOG-1:0]),
    .size      (cmd_size),
    .be        (cmd_be),
    .p_off     (p_off),
    .p_len     (p_len),
    .p_present (p_present),
    .p_en      (p_en)
  );

  // Compact enabled pieces into consecutive table slots, order preserved.
  always_comb begin
    n_cnt = '0;
    n_off = '0;
    n_len = '0;
    for (int i = 0; i < MAXF; i++) begin
      if (p_en[i]) begin
        n_off[n_cnt] = p_off[i];
        n_len[n_cnt] = p_len[i];
        n_cnt        = n_cnt + 1'b1;
      end
    end
  end

  assign multi     = |p_present[MAXF-1:1];

  assign cmd_ready = (st == FS_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign frg_valid = (st == FS_RUN) && (iss_q != gen_q);
  assign frg_fire  = frg_valid && frg_ready;
  assign rsp_ready = (st == FS_RUN) && (ret_q != iss_q);
  assign rsp_fire  = rsp_valid && rsp_ready;

  assign iss_off   = tbl_off_q[iss_q];
  assign ret_off   = tbl_off_q[ret_q];
  assign ret_len   = tbl_len_q[ret_q];

  assign frg_addr  = base_q + ADDR_W'(iss_off);
  assign frg_size  = tbl_len_q[iss_q];
  assign frg_write = wr_q;

  fsp_slice #(
    .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .OFF_W(OFF_W), .LEN_W(LEN_W)
  ) u_slice (
    .be_all   (be_q),
    .wd_all   (wd_q),
    .off      (iss_off),
    .len      (frg_size),
    .piece_be (frg_be),
    .piece_wd (frg_wdata)
  );

  fsp_assemble #(
    .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .OFF_W(OFF_W), .LEN_W(LEN_W)
  ) u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cmd_fire),
    .wr      (rsp_fire),
    .off     (ret_off),
    .len     (ret_len),
    .err_in  (rsp_err),
    .rdata   (rsp_rdata),
    .result  (done_rdata),
    .err_out (done_err)
  );

  assign done_valid   = (st == FS_DONE);
  assign done_illegal = ill_q;
  assign done_nfrag   = gen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FS_IDLE;
      base_q    <= '0;
      be_q      <= '0;
      wd_q      <= '0;
      wr_q      <= 1'b0;
      ill_q     <= 1'b0;
      tbl_off_q <= '0;
      tbl_len_q <= '0;
      gen_q     <= '0;
      iss_q     <= '0;
      ret_q     <= '0;
    end else begin
      case (st)
        FS_IDLE: begin
          if (cmd_valid) begin
            base_q    <= cmd_addr;
            be_q      <= cmd_be;
            wd_q      <= cmd_wdata;
            wr_q      <= cmd_write;
            tbl_off_q <= n_off;
            tbl_len_q <= n_len;
            iss_q     <= '0;
            ret_q     <= '0;
            if (cmd_atomic && multi) begin
              ill_q <= 1'b1;
              gen_q <= '0;
              st    <= FS_DONE;
            end else begin
              ill_q <= 1'b0;
              gen_q <= n_cnt;
              st    <= (n_cnt == '0) ? FS_DONE : FS_RUN;
            end
          end
        end
        FS_RUN: begin
          if (frg_fire) iss_q <= iss_q + 1'b1;
          if (rsp_fire) begin
            ret_q <= ret_q + 1'b1;
            if ((ret_q + 1'b1) == gen_q) st <= FS_DONE;
          end
        end
        FS_DONE: begin
          if (done_ready) st <= FS_IDLE;
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  AST_FRAG_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    frg_valid |-> ((LEN_W+1)'(frg_addr[LINE_LOG-1:0]) + (LEN_W+1)'(frg_size)) <= (LEN_W+1)'(LINE_BYTES)); // R5
  AST_FRAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frg_valid && !frg_ready) |=> (frg_valid && $stable(frg_addr) && $stable(frg_size) && $stable(frg_be))); // R4
  AST_FRAG_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    frg_fire |=> (!frg_valid || (frg_addr > $past(frg_addr)))); // R4
  AST_FRAG_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    frg_valid |-> (|frg_be)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!frg_valid && !rsp_ready && !done_valid)); // R11
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ready) |=> (done_valid && $stable(done_rdata) && $stable(done_err) && $stable(done_nfrag))); // R11
  AST_ILLEGAL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_illegal) |-> (done_nfrag == '0)); // R9
endmodule

// File: tb/line_frag_splitter_bench.sv
module line_frag_splitter_bench;
  localparam int LB = 8;
  localparam int MB = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [31:0]  cmd_addr = '0;
  logic [4:0]   cmd_size = '0;
  logic [15:0]  cmd_be = '0;
  logic         cmd_write = 1'b0;
  logic         cmd_atomic = 1'b0;
  logic [127:0] cmd_wdata = '0;
  logic         frg_valid;
  logic         frg_ready = 1'b0;
  logic [31:0]  frg_addr;
  logic [3:0]   frg_size;
  logic [7:0]   frg_be;
  logic         frg_write;
  logic [63:0]  frg_wdata;
  logic         rsp_valid = 1'b0;
  logic         rsp_ready;
  logic         rsp_err = 1'b0;
  logic [63:0]  rsp_rdata = '0;
  logic         done_valid;
  logic         done_ready = 1'b0;
  logic [127:0] done_rdata;
  logic         done_err;
  logic         done_illegal;
  logic [1:0]   done_nfrag;

  always #2 clk = ~clk;

  line_frag_splitter u_line_frag_splitter (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
    .cmd_be(cmd_be), .cmd_write(cmd_write), .cmd_atomic(cmd_atomic), .cmd_wdata(cmd_wdata),
    .frg_valid(frg_valid), .frg_ready(frg_ready), .frg_addr(frg_addr), .frg_size(frg_size),
    .frg_be(frg_be), .frg_write(frg_write), .frg_wdata(frg_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .done_valid(done_valid), .done_ready(done_ready), .done_rdata(done_rdata),
    .done_err(done_err), .done_illegal(done_illegal), .done_nfrag(done_nfrag)
  );

  typedef struct {
    logic [31:0] a;
    int          sz;
    logic [7:0]  be;
    logic [63:0] wd;
    bit          wr;
    string       tag;
  } frag_t;

  typedef struct {
    logic [127:0] rd;
    bit           err;
    bit           ill;
    int           n;
    string        tag;
  } done_t;

  frag_t       exp_f[$];
  done_t       exp_d[$];
  logic [31:0] pend_a[$];
  int          pend_s[$];

  int          checks = 0;
  int          failures = 0;
  bit          stall = 1'b0;
  logic [31:0] err_addr = 32'hFFFF_FFF0;

  function automatic logic [7:0] mb(input logic [31:0] a);
    return a[7:0] * 8'd7 + 8'h3C;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: computes expected pieces and completion, then offers the access.
  task automatic run_access(input logic [31:0] a, input int sz, input logic [15:0] be,
                            input bit wr, input bit at, input logic [127:0] wd, input string tag);
    frag_t        loc[$];
    done_t        d;
    int           o;
    int           raw;
    o = 0; raw = 0;
    d.rd = '0; d.err = 0; d.ill = 0; d.n = 0; d.tag = tag;
    while (o < sz) begin
      frag_t       f;
      logic [31:0] fa;
      int          ch;
      logic [15:0] sb;
      fa = a + o;
      ch = LB - int'(fa % LB);
      if (ch > sz - o) ch = sz - o;
      sb = (be >> o) & 16'((1 << ch) - 1);
      raw++;
      if (sb != 0) begin
        f.a = fa; f.sz = ch; f.be = sb[7:0]; f.wr = wr; f.tag = tag;
        f.wd = '0;
        for (int k = 0; k < ch; k++) f.wd[k*8 +: 8] = wd[(o+k)*8 +: 8];
        loc.push_back(f);
        d.n++;
        if (fa == err_addr) d.err = 1;
        else for (int k = 0; k < ch; k++) d.rd[(o+k)*8 +: 8] = mb(fa + k);
      end
      o += ch;
    end
    if (at && raw > 1) begin
      loc.delete();
      d.ill = 1; d.n = 0; d.rd = '0; d.err = 0;
    end
    foreach (loc[i]) exp_f.push_back(loc[i]);
    exp_d.push_back(d);
    @(negedge clk);
    cmd_addr = a; cmd_size = 5'(sz); cmd_be = be; cmd_write = wr;
    cmd_atomic = at; cmd_wdata = wd; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (exp_d.size() != 0) @(negedge clk);
  endtask

  // Monitor and responder: all handshake decisions at the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      frg_ready = stall ? (($urandom % 4) != 0) : 1'b1;
      if (frg_valid && frg_ready) begin
        if (exp_f.size() == 0) begin
          check(0, "R3", "unexpected piece addr", 128'(frg_addr), 128'h0);
        end else begin
          frag_t e;
          e = exp_f.pop_front();
          check(frg_addr == e.a, e.tag, "piece addr (R1 R4 R5)", 128'(frg_addr), 128'(e.a));
          check(int'(frg_size) == e.sz, e.tag, "piece size (R1 R5)", 128'(frg_size), 128'(e.sz));
          check(frg_be == e.be, e.tag, "piece enables (R12)", 128'(frg_be), 128'(e.be));
          check(frg_wdata == e.wd, e.tag, "piece wdata (R12)", 128'(frg_wdata), 128'(e.wd));
          check(frg_write == e.wr, e.tag, "piece direction", 128'(frg_write), 128'(e.wr));
        end
        pend_a.push_back(frg_addr);
        pend_s.push_back(int'(frg_size));
      end
      if (pend_a.size() > 0) begin
        rsp_valid = stall ? (($urandom % 3) != 0) : 1'b1;
        rsp_err   = (pend_a[0] == err_addr);
        rsp_rdata = '0;
        for (int k = 0; k < pend_s[0]; k++) rsp_rdata[k*8 +: 8] = mb(pend_a[0] + k);
        if (rsp_valid && rsp_ready) begin
          void'(pend_a.pop_front());
          void'(pend_s.pop_front());
        end
      end else begin
        rsp_valid = 1'b0;
      end
      done_ready = stall ? (($urandom % 2) != 0) : 1'b1;
      if (done_valid && done_ready) begin
        if (exp_d.size() == 0) begin
          check(0, "R8", "unexpected completion", 128'(done_nfrag), 128'h0);
        end else begin
          done_t e;
          e = exp_d.pop_front();
          check(exp_f.size() == 0 && pend_a.size() == 0, e.tag, "completion early (R8)",
                128'(exp_f.size() + pend_a.size()), 128'h0);
          check(done_rdata == e.rd, e.tag, "result data (R6)", done_rdata, e.rd);
          check(done_err == e.err, e.tag, "error flag (R7)", 128'(done_err), 128'(e.err));
          check(done_illegal == e.ill, e.tag, "illegal flag (R9)", 128'(done_illegal), 128'(e.ill));
          check(int'(done_nfrag) == e.n, e.tag, "piece count (R8)", 128'(done_nfrag), 128'(e.n));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_ready == 1'b0 || cmd_ready == 1'b1, "R11", "reset cmd_ready known", 128'(cmd_ready), 128'h1);
    check(cmd_ready == 1'b1, "R11", "cmd_ready in reset", 128'(cmd_ready), 128'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R11", "cmd_ready after reset", 128'(cmd_ready), 128'h1);
    check(frg_valid == 1'b0, "R11", "frg_valid after reset", 128'(frg_valid), 128'h0);
    check(rsp_ready == 1'b0, "R11", "rsp_ready after reset", 128'(rsp_ready), 128'h0);
    check(done_valid == 1'b0, "R11", "done_valid after reset", 128'(done_valid), 128'h0);

    run_access(32'h100, 8,  16'hFFFF, 0, 0, '0, "R2");
    run_access(32'h103, 4,  16'hFFFF, 0, 0, '0, "R2");
    run_access(32'h105, 12, 16'hFFFF, 0, 0, '0, "R1");
    run_access(32'h206, 16, 16'hFFFF, 0, 0, '0, "R1");
    run_access(32'h300, 16, 16'hFFFF, 0, 0, '0, "R1");
    run_access(32'h105, 12, 16'h0807, 0, 0, '0, "R3");
    run_access(32'h107, 10, 16'h0000, 0, 0, '0, "R10");
    run_access(32'h10B, 9, 16'h01FF, 1, 0, 128'h0F0E0D0C0B0A09080706050403020100, "R12");
    run_access(32'h10E, 4, 16'hFFFF, 0, 1, '0, "R9");
    run_access(32'h110, 4, 16'hFFFF, 0, 1, '0, "R9");
    err_addr = 32'h408;
    run_access(32'h404, 8, 16'hFFFF, 0, 0, '0, "R7");
    err_addr = 32'hFFFF_FFF0;

    stall = 1'b1;
    run_access(32'h51D, 15, 16'h7FFF, 1, 0, 128'hA5A4A3A2A1A09F9E9D9C9B9A99989796, "R4");
    run_access(32'h620, 16, 16'hFFFF, 0, 0, '0, "R11");
    for (int t = 0; t < 40; t++) begin
      logic [31:0] a;
      logic [15:0] be;
      int          sz;
      a  = 32'h1000 + ($urandom % 32'h4000);
      sz = 1 + int'($urandom % 16);
      be = (($urandom % 3) == 0) ? 16'($urandom) : 16'hFFFF;
      err_addr = (($urandom % 4) == 0) ? ((a + 32'd8) & ~32'd7) : 32'hFFFF_FFF0;
      run_access(a, sz, be, 1'($urandom), (($urandom % 6) == 0),
                 {$urandom, $urandom, $urandom, $urandom}, "R6");
    end
    stall = 1'b0;

    repeat (4) @(negedge clk);
    check(exp_f.size() == 0 && pend_a.size() == 0, "R8", "leftover pieces",
          128'(exp_f.size() + pend_a.size()), 128'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule